// File: doc/BRIEF.md
# Ordered Four-Rail Power Sequencer

This block switches on a set of supply rails (four by default) one at a time when a host sets an enable bit. Each rail has its own enable output and its own power-good input. A rail is only enabled once the rail before it reports good. If a rail does not report good within a set number of clock cycles, or a good flag drops while the rails are fully up, the block raises an alarm and records which rail failed. It then switches the rails off in reverse order.

When the enable bit is cleared, the rails go off in reverse order, one per clock. A fixed discharge hold-off, counted in clock cycles, follows before the block accepts a new power-up. This means a fast disable/enable sequence always runs through a full discharge. Because every wait has a timeout, a fast sequence can never leave the block stuck waiting for a power-good that will not come.

The host reaches the block through a byte-wide register port. It has a control byte, a status byte, a failure-cause byte and a fixed version byte. The power-good inputs come from analog regulators and are passed through two synchronizer flops before anything uses them.

Top module: `rseq_top`

## Requirements
- R1: After reset, all rail enables are 0, `pwr_ok` is 0, and the control, status and failure registers all read 0x00.
- R2: Address 0x2000 reads the version byte, which is 0x02 or 0x03 (0x03 by default).
- R3: Address 0x2006 is the control register. Bit 0 is the enable bit and reads back as written. Bits 7:1 always read 0.
- R4: Rails are enabled in ascending order starting at rail 0, one per clock at most. Rail k+1 is enabled only after the synchronized power-good of rail k is seen high.
- R5: Address 0x200A is the status register. Bits 3:0 are the synchronized power-good flags of rails 3..0, bit 4 is the alarm, and bits 7:5 are 0. With all rails up and no alarm it reads exactly 0x0F.
- R6: `pwr_ok` is high only while every rail is enabled, every synchronized power-good is high, and the alarm is clear.
- R7: If rail k has not reported good TIMEOUT_CYC cycles after it was enabled, the alarm sets in exactly that cycle. The failure register at 0x200B then reads k+1 in bits 2:0 with bit 7 = 0, and the rails shut down.
- R8: If any good flag drops while all rails are up, the alarm sets. The failure register reads 0x80 | (j+1), where j is the lowest dropped rail, and the rails shut down.
- R9: The alarm and failure register stay set, and no new power-up starts, for as long as the enable bit stays 1. Clearing the enable bit clears both on the next clock.
- R10: On disable or fault, rails turn off in descending order, one per clock, highest enabled rail first.
- R11: After the last rail turns off, no rail is enabled again for DISCH_CYC cycles. A pending enable turns on rail 0 exactly DISCH_CYC+1 cycles after the last rail turned off, and a rapid disable/enable sequence still reaches full power.
- R12: Writes to any address other than 0x2006 have no effect, and reads of unmapped addresses return 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 16 | Register byte address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| rail_pg | input | NUM_RAILS | Power-good flags from the regulators, asynchronous |
| rail_en | output | NUM_RAILS | Rail enables, bit 0 powered first |
| pwr_ok | output | 1 | All rails up and healthy |

## Verification
The assertions assume three things about the inputs. Reset is held low from time zero until after the first clock edge. Each register write is a single-cycle strobe. The power-good inputs may change at any time, so only the synchronized copies are compared against the enables. The bench meets these assumptions with a regulator model that raises a rail's good flag a fixed number of cycles after its enable and holds it for the same time after the enable is removed. A kill mask forces chosen flags low to create the timeout and dropout faults. Bus writes are driven on the falling edge for exactly one clock. The sweeps fail each rail in turn, both during ramp-up and while all rails are up. They also toggle the enable bit faster than the discharge hold-off allows.

// File: rtl/rseq_pkg.sv
// Shared definitions for the rail sequencer: register addresses and state encoding.
// Assumes a 16-bit byte address space decoded by exact match.
package rseq_pkg;
    localparam logic [15:0] ADDR_VER  = 16'h2000;
    localparam logic [15:0] ADDR_CTL  = 16'h2006;
    localparam logic [15:0] ADDR_STAT = 16'h200A;
    localparam logic [15:0] ADDR_FAIL = 16'h200B;

    typedef enum logic [2:0] {
        S_OFF,
        S_RAMP,
        S_ON,
        S_SHUT,
        S_DISCH
    } seq_state_t;
endpackage

// File: rtl/rseq_timer.sv
// Saturating cycle counter shared by the ramp timeout and the discharge hold-off.
// Assumes the sequencer pulses clr on every entry to a timed phase.
module rseq_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    output logic [CW-1:0] cnt
);
    // Count up from zero after clr, holding at the top value.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            cnt <= '0;
        else if (cnt != {CW{1'b1}})
            cnt <= cnt + CW'(1);
    end
endmodule

// File: rtl/rseq_fsm.sv
// Sequencing core: synchronizes power-good flags, walks rails up and down,
// and latches the alarm and failure cause. Assumes NUM_RAILS <= 6 so the
// failure code fits below bit 7.
module rseq_fsm
    import rseq_pkg::*;
#(
    parameter int NR          = 4,
    parameter int TIMEOUT_CYC = 64,
    parameter int DISCH_CYC   = 32,
    parameter int CW          = 8,
    parameter int IW          = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ctl_en,
    input  logic [NR-1:0] rail_pg,
    input  logic [CW-1:0] tmr_cnt,
    output logic          tmr_clr,
    output logic [NR-1:0] rail_en,
    output logic [NR-1:0] pg_sync,
    output logic          alarm,
    output logic [7:0]    fail_code,
    output logic          pwr_ok
);
    localparam logic [IW-1:0] LAST = IW'(NR - 1);
    localparam int PADW = 7 - (IW + 1);

    seq_state_t    state;
    logic [IW-1:0] idx;
    logic [NR-1:0] pg_meta;
    logic [IW-1:0] drop_idx;
    logic          all_good;
    logic          ramp_adv;
    logic          ramp_tmo;
    logic          dis_done;

    // Two-flop synchronizer for the asynchronous power-good flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pg_meta <= '0;
            pg_sync <= '0;
        end else begin
            pg_meta <= rail_pg;
            pg_sync <= pg_meta;
        end
    end

    // Locate the lowest rail whose good flag is low.
    always_comb begin
        drop_idx = '0;
        for (int i = NR - 1; i >= 0; i--)
            if (!pg_sync[i]) drop_idx = IW'(i);
    end

    assign all_good = &pg_sync;
    assign ramp_adv = (state == S_RAMP) && ctl_en && pg_sync[idx];
    assign ramp_tmo = (state == S_RAMP) && ctl_en && !pg_sync[idx]
                      && (tmr_cnt == CW'(TIMEOUT_CYC - 1));
    assign dis_done = (state == S_DISCH) && (tmr_cnt == CW'(DISCH_CYC - 1));

    // Restart the timer whenever a timed phase (rail ramp or discharge) begins.
    assign tmr_clr  = (state == S_OFF) || (state == S_SHUT) || ramp_adv;
    assign pwr_ok   = (state == S_ON) && all_good && !alarm;

    // Main sequencer: ramp up, hold, ramp down, discharge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= S_OFF;
            idx       <= '0;
            rail_en   <= '0;
            alarm     <= 1'b0;
            fail_code <= '0;
        end else begin
            unique case (state)
                S_OFF: begin
                    if (ctl_en && !alarm) begin
                        state      <= S_RAMP;
                        idx        <= '0;
                        rail_en[0] <= 1'b1;
                    end
                end
                S_RAMP: begin
                    if (!ctl_en) begin
                        state <= S_SHUT;
                    end else if (ramp_adv) begin
                        if (idx == LAST) begin
                            state <= S_ON;
                        end else begin
                            idx                 <= idx + IW'(1);
                            rail_en[idx + IW'(1)] <= 1'b1;
                        end
                    end else if (ramp_tmo) begin
                        alarm     <= 1'b1;
                        fail_code <= {1'b0, {PADW{1'b0}}, {1'b0, idx} + (IW+1)'(1)};
                        state     <= S_SHUT;
                    end
                end
                S_ON: begin
                    if (!ctl_en) begin
                        state <= S_SHUT;
                        idx   <= LAST;
                    end else if (!all_good) begin
                        alarm     <= 1'b1;
                        fail_code <= {1'b1, {PADW{1'b0}}, {1'b0, drop_idx} + (IW+1)'(1)};
                        state     <= S_SHUT;
                        idx       <= LAST;
                    end
                end
                S_SHUT: begin
                    rail_en[idx] <= 1'b0;
                    if (idx == '0) state <= S_DISCH;
                    else           idx   <= idx - IW'(1);
                end
                S_DISCH: begin
                    if (dis_done) state <= S_OFF;
                end
                default: state <= S_OFF;
            endcase
            if (!ctl_en) begin
                alarm     <= 1'b0;
                fail_code <= '0;
            end
        end
    end
endmodule

// File: rtl/rseq_regs.sv
// Byte register port: holds the enable bit and muxes read data.
// Assumes single-cycle write strobes and exact address decode.
module rseq_regs
    import rseq_pkg::*;
#(
    parameter logic [7:0] VERSION = 8'h03
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [15:0] bus_addr,
    input  logic        bus_wr,
    input  logic [7:0]  bus_wdata,
    input  logic [7:0]  stat_byte,
    input  logic [7:0]  fail_byte,
    output logic        ctl_en,
    output logic [7:0]  bus_rdata
);
    logic unused_wdata;
    assign unused_wdata = ^bus_wdata[7:1];

    // Capture the enable bit on writes to the control address.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctl_en <= 1'b0;
        else if (bus_wr && bus_addr == ADDR_CTL)
            ctl_en <= bus_wdata[0];
    end

    // Read multiplexer; unmapped addresses return zero.
    always_comb begin
        unique case (bus_addr)
            ADDR_VER:  bus_rdata = VERSION;
            ADDR_CTL:  bus_rdata = {7'b0, ctl_en};
            ADDR_STAT: bus_rdata = stat_byte;
            ADDR_FAIL: bus_rdata = fail_byte;
            default:   bus_rdata = 8'h00;
        endcase
    end
endmodule

// File: rtl/rseq_top.sv
// Ordered multi-rail power sequencer with register access, fault latching
// and a discharge hold-off. Assumes NUM_RAILS between 1 and 6 and both
// cycle counts at least 2.
module rseq_top #(
    parameter int         NUM_RAILS   = 4,
    parameter int         TIMEOUT_CYC = 50000,
    parameter int         DISCH_CYC   = 25000,
    parameter logic [7:0] VERSION     = 8'h03
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [15:0]          bus_addr,
    input  logic                 bus_wr,
    input  logic [7:0]           bus_wdata,
    output logic [7:0]           bus_rdata,
    input  logic [NUM_RAILS-1:0] rail_pg,
    output logic [NUM_RAILS-1:0] rail_en,
    output logic                 pwr_ok
);
    localparam int TMAX = (TIMEOUT_CYC > DISCH_CYC) ? TIMEOUT_CYC : DISCH_CYC;
    localparam int CW   = $clog2(TMAX + 1);
    localparam int IW   = (NUM_RAILS > 1) ? $clog2(NUM_RAILS) : 1;

    logic                 ctl_en;
    logic                 alarm;
    logic                 tmr_clr;
    logic [CW-1:0]        tmr_cnt;
    logic [NUM_RAILS-1:0] pg_sync;
    logic [7:0]           fail_code;
    logic [7:0]           stat_byte;

    assign stat_byte = 8'({alarm, pg_sync});

    rseq_regs #(.VERSION(VERSION)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .stat_byte (stat_byte),
        .fail_byte (fail_code),
        .ctl_en    (ctl_en),
        .bus_rdata (bus_rdata)
    );

    rseq_timer #(.CW(CW)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tmr_clr),
        .cnt   (tmr_cnt)
    );

    rseq_fsm #(
        .NR          (NUM_RAILS),
        .TIMEOUT_CYC (TIMEOUT_CYC),
        .DISCH_CYC   (DISCH_CYC),
        .CW          (CW),
        .IW          (IW)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl_en    (ctl_en),
        .rail_pg   (rail_pg),
        .tmr_cnt   (tmr_cnt),
        .tmr_clr   (tmr_clr),
        .rail_en   (rail_en),
        .pg_sync   (pg_sync),
        .alarm     (alarm),
        .fail_code (fail_code),
        .pwr_ok    (pwr_ok)
    );
endmodule

// File: rtl/rseq_chk.sv
// Property checker for the rail sequencer, bound into rseq_top.
// Assumes reset is low from time zero through the first clock edge.
module rseq_chk
    import rseq_pkg::*;
#(
    parameter int NR = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ctl_en,
    input logic          alarm,
    input logic [NR-1:0] rail_en,
    input logic          pwr_ok,
    input logic [15:0]   bus_addr,
    input logic [7:0]    bus_rdata
);
    // R4
    rail_thermo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rail_en & (rail_en + NR'(1))) == '0);

    // R10
    rail_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(rail_en ^ $past(rail_en)) <= 1);

    // R4
    start_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rail_en != '0 && $past(rail_en) == '0) |-> $past(ctl_en));

    // R9
    alarm_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_en |=> !alarm);

    // R6
    pwr_ok_rails_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_ok |-> ((&rail_en) && !alarm));

    // R2
    version_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_VER) |-> (bus_rdata == 8'h02 || bus_rdata == 8'h03));
endmodule

bind rseq_top rseq_chk #(.NR(NUM_RAILS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl_en    (ctl_en),
    .alarm     (alarm),
    .rail_en   (rail_en),
    .pwr_ok    (pwr_ok),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata)
);

// File: tb/test_rseq_top.sv
module test_rseq_top;
    import rseq_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int NR         = 4;
    localparam int T_TO       = 40;
    localparam int T_DIS      = 20;
    localparam int ON_DLY     = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [15:0]   bus_addr = ADDR_STAT;
    logic          bus_wr = 1'b0;
    logic [7:0]    bus_wdata = 8'h00;
    logic [7:0]    bus_rdata;
    logic [NR-1:0] rail_pg;
    logic [NR-1:0] rail_en;
    logic          pwr_ok;
    logic [NR-1:0] pg_model;
    logic [NR-1:0] kill_mask = '0;
    int            n_checks = 0;
    int            n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rseq_top #(.NUM_RAILS(NR), .TIMEOUT_CYC(T_TO), .DISCH_CYC(T_DIS), .VERSION(8'h03)) i_rseq_top (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rail_pg(rail_pg),
        .rail_en(rail_en), .pwr_ok(pwr_ok)
    );

    // Regulator model: good ON_DLY cycles after enable, discharges over the same time.
    int lvl [NR];
    always_ff @(posedge clk) begin
        for (int i = 0; i < NR; i++) begin
            if (!rst_n)          lvl[i] <= 0;
            else if (rail_en[i]) lvl[i] <= (lvl[i] < ON_DLY) ? lvl[i] + 1 : lvl[i];
            else                 lvl[i] <= (lvl[i] > 0) ? lvl[i] - 1 : 0;
        end
    end
    always_comb begin
        for (int i = 0; i < NR; i++)
            pg_model[i] = rail_en[i] ? (lvl[i] == ON_DLY) : (lvl[i] != 0);
    end
    assign rail_pg = pg_model & ~kill_mask;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic write_reg(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = ADDR_STAT;
    endtask

    task automatic read_reg(input logic [15:0] a, output logic [7:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
        bus_addr = ADDR_STAT;
    endtask

    task automatic wait_up(input int lim, output bit ok);
        ok = 1'b0;
        for (int c = 0; c < lim && !ok; c++) begin
            @(negedge clk);
            if (pwr_ok) ok = 1'b1;
        end
    endtask

    task automatic wait_off(input int lim, output bit ok);
        ok = 1'b0;
        for (int c = 0; c < lim && !ok; c++) begin
            @(negedge clk);
            if (rail_en == '0) ok = 1'b1;
        end
    endtask

    // Order monitor: rails rise in ascending order after the previous good, fall descending.
    logic [NR-1:0] prev_en = '0;
    int pg_hi [NR];
    always @(negedge clk) begin
        if (!rst_n) begin
            prev_en = '0;
            for (int i = 0; i < NR; i++) pg_hi[i] = 0;
        end else begin
            if (rail_en != prev_en) begin
                if ((rail_en & ~prev_en) != '0) begin
                    int nb;
                    nb = 0;
                    for (int i = 0; i < NR; i++) if (rail_en[i] && !prev_en[i]) nb = i;
                    // R4 ascending one-rail step
                    check(rail_en == ((prev_en << 1) | NR'(1)), "R4", rail_en, (prev_en << 1) | NR'(1));
                    if (nb > 0) check(pg_hi[nb-1] >= 2, "R4", pg_hi[nb-1], 2);
                end else begin
                    // R10 highest rail off first
                    check(rail_en == (prev_en >> 1), "R10", rail_en, prev_en >> 1);
                end
            end
            prev_en = rail_en;
            for (int i = 0; i < NR; i++) pg_hi[i] = rail_pg[i] ? pg_hi[i] + 1 : 0;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] v;
        bit ok;
        int n0, n1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check(rail_en == '0, "R1", rail_en, 0);
        check(pwr_ok == 1'b0, "R1", pwr_ok, 0);
        read_reg(ADDR_CTL, v);  check(v == 8'h00, "R1", v, 0);
        read_reg(ADDR_STAT, v); check(v == 8'h00, "R1", v, 0);
        read_reg(ADDR_FAIL, v); check(v == 8'h00, "R1", v, 0);
        // R2 version
        read_reg(ADDR_VER, v);  check(v == 8'h03, "R2", v, 3);

        // R12 stray writes and unmapped reads
        write_reg(16'h2005, 8'hFF);
        write_reg(16'h0006, 8'hFF);
        write_reg(ADDR_STAT, 8'hFF);
        repeat (10) @(negedge clk);
        check(rail_en == '0, "R12", rail_en, 0);
        read_reg(ADDR_CTL, v);  check(v == 8'h00, "R12", v, 0);
        read_reg(16'h2001, v);  check(v == 8'h00, "R12", v, 0);
        read_reg(16'h200C, v);  check(v == 8'h00, "R12", v, 0);

        // R3 enable with extra bits set; R5/R6 full power
        write_reg(ADDR_CTL, 8'hFF);
        read_reg(ADDR_CTL, v);  check(v == 8'h01, "R3", v, 1);
        wait_up(200, ok);
        check(ok, "R6", ok, 1);
        check(rail_en == '1, "R6", rail_en, 4'hF);
        read_reg(ADDR_STAT, v); check(v == 8'h0F, "R5", v, 8'h0F);

        // R11 disable then re-enable during shutdown: exact hold-off
        write_reg(ADDR_CTL, 8'h00);
        read_reg(ADDR_CTL, v);  check(v == 8'h00, "R3", v, 0);
        write_reg(ADDR_CTL, 8'h01);
        wait_off(50, ok);
        check(ok, "R10", ok, 1);
        n0 = 0;
        while (rail_en == '0 && n0 < 4 * T_DIS) begin
            @(negedge clk);
            n0++;
        end
        check(n0 == T_DIS + 1, "R11", n0, T_DIS + 1);
        wait_up(200, ok);
        check(ok, "R11", ok, 1);

        // R11 rapid toggling must still reach full power without alarm
        for (int r = 0; r < 3; r++) begin
            write_reg(ADDR_CTL, 8'h00);
            repeat (r + 1) @(negedge clk);
            write_reg(ADDR_CTL, 8'h01);
            repeat (3 * r) @(negedge clk);
        end
        wait_up(400, ok);
        check(ok, "R11", ok, 1);
        read_reg(ADDR_STAT, v); check(v == 8'h0F, "R11", v, 8'h0F);
        write_reg(ADDR_CTL, 8'h00);
        wait_off(50, ok);
        repeat (T_DIS + 10) @(negedge clk);

        // R7 ramp timeout sweep over every rail
        for (int k = 0; k < NR; k++) begin
            kill_mask = NR'(1) << k;
            write_reg(ADDR_CTL, 8'h01);
            n0 = -1; n1 = -1;
            for (int c = 0; c < 400 && n1 < 0; c++) begin
                @(negedge clk);
                bus_addr = ADDR_STAT;
                #1;
                if (n0 < 0 && rail_en[k]) n0 = c;
                if (bus_rdata[4]) n1 = c;
            end
            check(n0 >= 0 && n1 - n0 == T_TO, "R7", n1 - n0, T_TO);
            read_reg(ADDR_FAIL, v); check(v == 8'(k + 1), "R7", v, k + 1);
            wait_off(20, ok);
            check(ok, "R7", rail_en, 0);
            // R9 alarm held, no restart while enable stays set
            repeat (3 * T_DIS) @(negedge clk);
            check(rail_en == '0, "R9", rail_en, 0);
            read_reg(ADDR_STAT, v); check(v[4] == 1'b1, "R9", v, 8'h10);
            kill_mask = '0;
            write_reg(ADDR_CTL, 8'h00);
            @(negedge clk);
            read_reg(ADDR_STAT, v); check(v[4] == 1'b0, "R9", v[4], 0);
            read_reg(ADDR_FAIL, v); check(v == 8'h00, "R9", v, 0);
            repeat (T_DIS + 10) @(negedge clk);
        end

        // R8 dropout sweep over every rail
        for (int k = 0; k < NR; k++) begin
            write_reg(ADDR_CTL, 8'h01);
            wait_up(200, ok);
            check(ok, "R8", ok, 1);
            @(negedge clk);
            kill_mask = NR'(1) << k;
            ok = 1'b0;
            for (int c = 0; c < 20 && !ok; c++) begin
                @(negedge clk);
                bus_addr = ADDR_STAT;
                #1;
                if (bus_rdata[4]) ok = 1'b1;
            end
            check(ok, "R8", ok, 1);
            check(pwr_ok == 1'b0, "R6", pwr_ok, 0);
            read_reg(ADDR_FAIL, v); check(v == (8'h80 | 8'(k + 1)), "R8", v, 8'h80 | 8'(k + 1));
            wait_off(20, ok);
            check(ok, "R8", rail_en, 0);
            kill_mask = '0;
            write_reg(ADDR_CTL, 8'h00);
            @(negedge clk);
            read_reg(ADDR_FAIL, v); check(v == 8'h00, "R9", v, 0);
            repeat (T_DIS + 10) @(negedge clk);
        end

        // Recovery after all faults
        write_reg(ADDR_CTL, 8'h01);
        wait_up(200, ok);
        check(ok, "R6", ok, 1);
        read_reg(ADDR_STAT, v); check(v == 8'h0F, "R5", v, 8'h0F);

        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule